// File: doc/BRIEF.md
# OTG Status Interrupt Controller

This block watches four status levels of a dual-role USB port: VBUS above the valid level, VBUS above the session-valid level, VBUS above the session-end level, and the ID pin tied to ground. The comparators themselves are outside the block. Their results arrive as digital levels, and each one passes through a synchronizer before edge detection. A rising or falling edge of a source is recorded in a flag register when that edge is enabled for that source. There is one enable register for rising edges and a separate one for falling edges. Software clears a flag by writing a one to its bit.

Any recorded flag whose source still has an edge enabled pulls the interrupt output low. The interrupt output can be configured as open-drain or push-pull. In open-drain mode it is modelled as a drive-low enable. In push-pull mode it drives both levels. The pin that normally carries the transceiver's output-enable can also carry the interrupt. This happens only while the port is suspended and the mirror bit is set. At all other times the block leaves that pin undriven.

A simple register port gives access to five words: the flags, the two enable masks, a configuration word and a read-only view of the synchronized levels.

Top module: `otg_irq_ctrl`

## Requirements
- R1: Each source has a fixed bit in the flag, rise-enable, fall-enable and live-status words: VBUS-valid at bit 0, session-valid at bit 1, ID-grounded at bit 4, session-end at bit 7. The live-status word at address 4 shows the synchronized levels of the sources.
- R2: After an input changes, the live-status word shows the new value once two clock edges have passed. The flag for that change is set on the third clock edge and not before.
- R3: A rising edge of a source sets its flag only when that source's bit in the rise-enable word (address 1) is 1.
- R4: A falling edge of a source sets its flag only when that source's bit in the fall-enable word (address 2) is 1.
- R5: Writing to the flag word (address 0) clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A flag that is being set in the same cycle as a clear write stays set.
- R6: An interrupt is pending while any flag is set whose rise-enable or fall-enable bit is also 1. Clearing both enable bits of a set flag removes it from the pending condition, but the flag stays recorded.
- R7: When configuration bit 0 (address 3) is 0, the output is open-drain. `irq_o` is always 0, and `irq_oe_o` is 1 exactly while an interrupt is pending.
- R8: When configuration bit 0 is 1, the output is push-pull. `irq_oe_o` is always 1, and `irq_o` is 0 while an interrupt is pending and 1 otherwise.
- R9: While `suspend_i` is 1 and configuration bit 1 is 1, `share_o` and `share_oe_o` equal `irq_o` and `irq_oe_o`. Otherwise both are 0.
- R10: Reset clears the flags, both enable words and the configuration word. After reset the interrupt is therefore open-drain and released.
- R11: Register bits with no source, configuration bits 2 to 7, and addresses 5 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbus_ok_i | input | 1 | VBUS above the valid level |
| sess_ok_i | input | 1 | VBUS above the session-valid level |
| sess_end_i | input | 1 | VBUS above the session-end level |
| id_gnd_i | input | 1 | ID pin grounded |
| suspend_i | input | 1 | Port is in suspend |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt level, active low |
| irq_oe_o | output | 1 | Interrupt driver enable |
| share_o | output | 1 | Shared-pin level while mirroring |
| share_oe_o | output | 1 | Shared-pin driver enable |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and an 8-bit register word. With two stages, the latency of R2 is exact and short. This lets a write be placed on the very edge at which an edge flag is set, so the collision case of R5 is reached. The 8-bit word includes positions 2, 3, 5 and 6, which have no source. This brings the masking rules of R11 within reach, alongside both output modes and the mirror gating.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    // Register positions of the status sources
    localparam int POS_VBUS = 0;
    localparam int POS_SESS = 1;
    localparam int POS_ID   = 4;
    localparam int POS_SEND = 7;

    localparam logic [REG_W-1:0] SRC_MASK =
        REG_W'((1 << POS_VBUS) | (1 << POS_SESS) | (1 << POS_ID) | (1 << POS_SEND));

    typedef enum logic [ADDR_W-1:0] {
        ADR_FLAGS = 3'd0,
        ADR_RISE  = 3'd1,
        ADR_FALL  = 3'd2,
        ADR_CFG   = 3'd3,
        ADR_LIVE  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic mirror_en;
        logic push_pull;
    } irq_cfg_t;

    typedef struct packed {
        logic lvl;
        logic oe;
    } pin_drv_t;

    function automatic logic [REG_W-1:0] place_sources(
        input logic vbus, input logic sess, input logic idg, input logic send);
        logic [REG_W-1:0] v;
        v = '0;
        v[POS_VBUS] = vbus;
        v[POS_SESS] = sess;
        v[POS_ID]   = idg;
        v[POS_SEND] = send;
        return v;
    endfunction

    function automatic pin_drv_t pin_drive(input logic pending, input logic push_pull);
        pin_drv_t p;
        if (push_pull) begin
            p.oe  = 1'b1;
            p.lvl = ~pending;
        end else begin
            p.oe  = pending;
            p.lvl = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/otg_sync_edge.sv
module otg_sync_edge #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            prev <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign level = stg[STAGES-1];
    assign rise  = stg[STAGES-1] & ~prev;
    assign fall  = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/otg_irq_regs.sv
module otg_irq_regs
    import otg_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  rise_ev,
    input  logic [REG_W-1:0]  fall_ev,
    input  logic [REG_W-1:0]  live,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  flags,
    output logic [REG_W-1:0]  rise_en,
    output logic [REG_W-1:0]  fall_en,
    output irq_cfg_t          cfg
);
    reg_addr_e        sel;
    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] set_mask;

    assign sel      = reg_addr_e'(addr);
    assign clr_mask = (wr && sel == ADR_FLAGS) ? wdata : '0;
    assign set_mask = ((rise_ev & rise_en) | (fall_ev & fall_en)) & SRC_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            rise_en <= '0;
            fall_en <= '0;
            cfg     <= '0;
        end else begin
            // a new edge outranks a clear in the same cycle
            flags <= (flags & ~clr_mask) | set_mask;
            if (wr) begin
                case (sel)
                    ADR_RISE: rise_en <= wdata & SRC_MASK;
                    ADR_FALL: fall_en <= wdata & SRC_MASK;
                    ADR_CFG:  cfg     <= irq_cfg_t'(wdata[1:0]);
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            ADR_FLAGS: rdata = flags;
            ADR_RISE:  rdata = rise_en;
            ADR_FALL:  rdata = fall_en;
            ADR_CFG:   rdata = REG_W'(cfg);
            ADR_LIVE:  rdata = live & SRC_MASK;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/otg_irq_pin.sv
module otg_irq_pin
    import otg_irq_pkg::*;
(
    input  logic pending,
    input  logic push_pull,
    input  logic active,
    output logic lvl,
    output logic oe
);
    pin_drv_t d;

    assign d   = pin_drive(pending, push_pull);
    assign lvl = active & d.lvl;
    assign oe  = active & d.oe;
endmodule

// File: rtl/otg_irq_ctrl.sv
module otg_irq_ctrl
    import otg_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vbus_ok_i,
    input  logic              sess_ok_i,
    input  logic              sess_end_i,
    input  logic              id_gnd_i,
    input  logic              suspend_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o,
    output logic              irq_oe_o,
    output logic              share_o,
    output logic              share_oe_o
);
    logic [REG_W-1:0] raw;
    logic [REG_W-1:0] live;
    logic [REG_W-1:0] rise_ev;
    logic [REG_W-1:0] fall_ev;
    logic [REG_W-1:0] flags;
    logic [REG_W-1:0] rise_en;
    logic [REG_W-1:0] fall_en;
    irq_cfg_t         cfg;
    logic             pending;
    logic             mirror_on;

    assign raw = place_sources(vbus_ok_i, sess_ok_i, id_gnd_i, sess_end_i);

    otg_sync_edge #(.W(REG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (raw),
        .level (live),
        .rise  (rise_ev),
        .fall  (fall_ev)
    );

    otg_irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .live    (live),
        .wr      (reg_wr_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .rdata   (reg_rdata_o),
        .flags   (flags),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .cfg     (cfg)
    );

    assign pending   = |(flags & (rise_en | fall_en));
    assign mirror_on = suspend_i & cfg.mirror_en;

    otg_irq_pin u_main (
        .pending   (pending),
        .push_pull (cfg.push_pull),
        .active    (1'b1),
        .lvl       (irq_o),
        .oe        (irq_oe_o)
    );

    otg_irq_pin u_share (
        .pending   (pending),
        .push_pull (cfg.push_pull),
        .active    (mirror_on),
        .lvl       (share_o),
        .oe        (share_oe_o)
    );
endmodule

// File: rtl/otg_irq_ctrl_chk.sv
module otg_irq_ctrl_chk
    import otg_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] flags,
    input logic [REG_W-1:0] rise_en,
    input logic [REG_W-1:0] fall_en,
    input irq_cfg_t         cfg,
    input logic             suspend_i,
    input logic             irq_o,
    input logic             irq_oe_o,
    input logic             share_o,
    input logic             share_oe_o
);
    // R3 / R4: a flag only appears where an edge enable was set
    a_r3_no_unenabled_flag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(rise_en | fall_en)) == '0));

    // R6: pending condition seen at the pin
    a_r6_pending_at_pin: assert property (@(posedge clk) disable iff (rst)
        (|(flags & (rise_en | fall_en))) == (irq_oe_o && !irq_o));

    // R7
    a_r7_open_drain_low: assert property (@(posedge clk) disable iff (rst)
        !cfg.push_pull |-> !irq_o);

    // R8
    a_r8_push_pull_driven: assert property (@(posedge clk) disable iff (rst)
        cfg.push_pull |-> irq_oe_o);

    // R9
    a_r9_share_released: assert property (@(posedge clk) disable iff (rst)
        !(suspend_i && cfg.mirror_en) |-> (!share_oe_o && !share_o));

    a_r9_share_mirrors: assert property (@(posedge clk) disable iff (rst)
        (suspend_i && cfg.mirror_en) |-> (share_oe_o == irq_oe_o && share_o == irq_o));
endmodule

bind otg_irq_ctrl otg_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .flags      (flags),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .cfg        (cfg),
    .suspend_i  (suspend_i),
    .irq_o      (irq_o),
    .irq_oe_o   (irq_oe_o),
    .share_o    (share_o),
    .share_oe_o (share_oe_o)
);

// File: tb/test_otg_irq_ctrl.sv
`timescale 1ns/1ps
module test_otg_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vbus = 1'b0, sess = 1'b0, send = 1'b0, idg = 1'b0, susp = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, irq_oe, sh, sh_oe;
    int         vectors = 0;
    int         miscompares = 0;

    always #2 clk = ~clk;

    otg_irq_ctrl i_otg_irq_ctrl (
        .clk(clk), .rst(rst),
        .vbus_ok_i(vbus), .sess_ok_i(sess), .sess_end_i(send), .id_gnd_i(idg),
        .suspend_i(susp), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .irq_oe_o(irq_oe),
        .share_o(sh), .share_oe_o(sh_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #0.5 d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rreg(3'(a), d); check("R10 register cleared", d, 8'h00);
        end
        check("R10 irq released", {6'd0, irq_oe, sh_oe}, 8'h00);
    endtask

    task automatic t_map_latency();
        logic [7:0] d;
        wreg(3'd1, 8'hFF);
        rreg(3'd1, d); check("R11 rise mask", d, 8'h93);
        @(negedge clk); sess = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        addr = 3'd4; #0.5 check("R2 live after two edges", rdata, 8'h02);
        addr = 3'd0; #0.5 check("R2 flag not yet", rdata, 8'h00);
        @(posedge clk); @(negedge clk);
        addr = 3'd0; #0.5 check("R2 flag on third edge", rdata, 8'h02);
        vbus = 1'b1; idg = 1'b1; send = 1'b1;
        settle();
        rreg(3'd4, d); check("R1 live positions", d, 8'h93);
        rreg(3'd0, d); check("R1 flag positions", d, 8'h93);
        wreg(3'd1, 8'h00);
        wreg(3'd0, 8'hFF);
        @(negedge clk); vbus = 0; sess = 0; idg = 0; send = 0;
        settle();
        rreg(3'd0, d); check("R4 falls ignored when disabled", d, 8'h00);
    endtask

    task automatic t_edges();
        logic [7:0] d;
        wreg(3'd1, 8'h01);
        @(negedge clk); vbus = 1'b1; idg = 1'b1;
        settle();
        rreg(3'd0, d); check("R3 only enabled rise", d, 8'h01);
        wreg(3'd0, 8'h01);
        wreg(3'd2, 8'h80);
        @(negedge clk); send = 1'b1; vbus = 1'b0; idg = 1'b0;
        settle();
        rreg(3'd0, d); check("R3 rise of bit7 without enable", d, 8'h00);
        @(negedge clk); send = 1'b0;
        settle();
        rreg(3'd0, d); check("R4 enabled fall", d, 8'h80);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        wreg(3'd1, 8'h01); wreg(3'd2, 8'h01);
        @(negedge clk); vbus = 1'b1;
        settle();
        rreg(3'd0, d); check("R5 setup", d, 8'h81);
        wreg(3'd0, 8'h01);
        rreg(3'd0, d); check("R5 partial clear", d, 8'h80);
        wreg(3'd0, 8'h00);
        rreg(3'd0, d); check("R5 zero write keeps", d, 8'h80);
        wreg(3'd0, 8'h80);
        wreg(3'd0, 8'h00);
        // re-set bit0 by rise, then collide a clear with the fall edge
        @(negedge clk); vbus = 1'b0;
        settle();
        @(negedge clk); vbus = 1'b1;
        settle();
        @(negedge clk); vbus = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); wr = 1'b1; addr = 3'd0; wdata = 8'h01;
        @(negedge clk); wr = 1'b0;
        rreg(3'd0, d); check("R5 set wins over clear", d, 8'h01);
        wreg(3'd0, 8'h01);
        rreg(3'd0, d); check("R5 plain clear", d, 8'h00);
    endtask

    task automatic t_modes();
        // flag bit0 clear; enables rise/fall bit0
        @(negedge clk); #0.5;
        check("R7 idle open-drain", {6'd0, irq_oe, irq}, 8'h00);
        vbus = 1'b1;
        settle(); #0.5;
        check("R7 pending open-drain", {6'd0, irq_oe, irq}, 8'h02);
        wreg(3'd3, 8'h01); #0.5;
        check("R8 pending push-pull", {6'd0, irq_oe, irq}, 8'h02);
        wreg(3'd1, 8'h00); wreg(3'd2, 8'h00); #0.5;
        check("R6 masked flag not pending", {6'd0, irq_oe, irq}, 8'h03);
        begin
            logic [7:0] d;
            rreg(3'd0, d); check("R6 flag kept", d, 8'h01);
        end
        wreg(3'd3, 8'h00); #0.5;
        check("R7 released when masked", {6'd0, irq_oe, irq}, 8'h00);
        wreg(3'd1, 8'h01);
    endtask

    task automatic t_mirror();
        @(negedge clk); susp = 1'b1; #0.5;
        check("R9 no mirror without enable", {6'd0, sh_oe, sh}, 8'h00);
        wreg(3'd3, 8'h02); #0.5;
        check("R9 mirror open-drain", {6'd0, sh_oe, sh}, 8'h02);
        wreg(3'd3, 8'h03); #0.5;
        check("R9 mirror push-pull", {6'd0, sh_oe, sh}, 8'h02);
        wreg(3'd0, 8'h01); #0.5;
        check("R9 mirror push-pull idle", {6'd0, sh_oe, sh}, 8'h03);
        susp = 1'b0; #0.5;
        check("R9 released out of suspend", {6'd0, sh_oe, sh}, 8'h00);
    endtask

    task automatic t_unimpl();
        logic [7:0] d;
        wreg(3'd3, 8'hFC);
        rreg(3'd3, d); check("R11 cfg upper bits", d, 8'h00);
        wreg(3'd5, 8'hFF);
        rreg(3'd5, d); check("R11 unused address reads 0", d, 8'h00);
        rreg(3'd1, d); check("R11 unused address no effect", d, 8'h01);
        wreg(3'd2, 8'hFF);
        rreg(3'd2, d); check("R11 fall mask", d, 8'h93);
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: all requirements, actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_map_latency();
        t_edges();
        t_w1c();
        t_modes();
        t_mirror();
        t_unimpl();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule